// File: doc/BRIEF.md
# PLL Bypass and System Clock Selector

This block decides where the system clock comes from. Either a raw oscillator is passed straight through, or a PLL output is passed through an optional integer divider. Clocks are modelled as one-cycle enable pulses ("ticks") on a single fast clock, so selection is ordinary logic. The block also reports when the PLL has locked.

Software sets the selection through a small write-only register bus. A legacy configuration word holds bypass, use-divider, power-down, crystal code, oscillator select and a 4-bit divider. An extended word can override bypass, power-down, oscillator select and divider, this time with a 6-bit divider. The extended word takes effect only while its enable bit is set. The crystal code indexes a computed table that gives the PLL multiplier and reference divider. A code with no table entry is flagged and keeps the PLL unpowered.

A four-state path machine governs the handover between the raw path and the PLL path. The states are RAW, TO_PLL, PLL and TO_RAW. Each of the two transitional states lasts one cycle and emits no tick, so the system clock never carries a pulse from both sources back to back. A lock status bit captures the rising edge of the PLL lock input. Software can poll that bit, clear it, and mask it onto an interrupt output.

Top module: `pll_clk_selector`

## Requirements
- R1: While the path state is RAW (encoding 0), `sys_tick` equals `osc_tick[s]` in the same cycle, where s is the effective oscillator select, and `div_eff` reads 1.
- R2: In the PLL state, if use-divider (legacy bit 1) is set, `sys_tick` fires once every d+1 cycles of `pll_tick`, where d is the effective divider field, and `div_eff` reads d+1. With use-divider clear, every `pll_tick` passes and `div_eff` reads 1. The count restarts at zero on entry to PLL, so with `pll_tick` held high the first pulse comes in the (d+1)-th PLL cycle.
- R3: `pll_pwr_en` is 1 exactly when the effective power-down bit is 0 and the crystal code is valid.
- R4: Crystal code c is legacy bits [7:3]. For 4 <= c <= 15 the outputs are `xtal_bad`=0, `pll_mult`=2c+8 and `pll_refdiv`=floor(c/4)+1. For any other code they are `xtal_bad`=1, `pll_mult`=0 and `pll_refdiv`=0.
- R5: While the extended enable (extended bit 0) is 1, bypass, power-down, oscillator select and divider come from the extended word: bypass bit 1, power-down bit 2, oscillator select bits [4:3], divider bits [10:5]. Use-divider and the crystal code always come from the legacy word. While the extended enable is 0, the extended word has no effect.
- R6: `lock_raw` goes to 1 in the cycle after a rising edge of `pll_lock`. Writing 1 in data bit 0 to address 2 clears it. Writing 0 there leaves it unchanged. A steady-high `pll_lock` does not set it again. If a rising edge and a clear arrive in the same cycle, the set wins.
- R7: `lock_irq` equals `lock_raw` AND the mask bit, which is data bit 0 written to address 3.
- R8: If the effective power-down bit is set or the crystal code is invalid, the block uses the raw path even when bypass is clear. It therefore never enters or stays in PLL while `pll_pwr_en` is 0.
- R9: `src_state` encodes the path as RAW=0, TO_PLL=1, PLL=2, TO_RAW=3. The transitions are:
  - RAW goes to TO_PLL when the effective bypass drops.
  - TO_PLL goes to PLL, or back to RAW if bypass has returned.
  - PLL goes to TO_RAW when the effective bypass rises.
  - TO_RAW always goes to RAW.

  A configuration write therefore reaches the new steady state two cycles after its write edge, and `sys_tick` is 0 in both transitional states.
- R10: Reset leaves the legacy word with bypass=1, power-down=1, crystal code 6 and all other fields 0, and clears the extended word and the mask. So after reset `src_state`=0, `pll_pwr_en`=0, `pll_mult`=20, `pll_refdiv`=2, `lock_raw`=0, `lock_irq`=0 and `div_eff`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock; all ticks are enables on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 legacy word, 1 extended word, 2 lock clear, 3 interrupt mask |
| wr_data | input | 32 | Write data |
| pll_lock | input | 1 | Lock indication from the PLL |
| osc_tick | input | 4 | Clock-enable pulses of the four raw oscillators |
| pll_tick | input | 1 | Clock-enable pulse of the PLL output |
| pll_pwr_en | output | 1 | PLL power and output enable |
| pll_mult | output | 8 | PLL multiplier from the crystal table |
| pll_refdiv | output | 4 | PLL reference divider from the crystal table |
| xtal_bad | output | 1 | Crystal code has no table entry |
| src_state | output | 2 | Path state: RAW, TO_PLL, PLL, TO_RAW |
| div_eff | output | 7 | Divide ratio currently applied to the selected source |
| sys_tick | output | 1 | System clock enable |
| lock_raw | output | 1 | Raw lock status |
| lock_irq | output | 1 | Masked lock interrupt |

## Verification
All 32 crystal codes are swept. This separates the table's arithmetic from its validity window, and shows that an invalid code turns the PLL off and pulls the path back to raw. Every divider value is tried through both the 4-bit legacy field and the 6-bit extended field, with the PLL tick held high. The pulse count over a fixed window then equals the window length divided by the ratio, which exposes an off-by-one in the wrap and any mix-up between the two fields. The four oscillators carry ticks with co-prime periods, so a wrong select shows up as a mismatch within a few cycles; this is done with and without the extended word overriding the legacy select. Lock edges are applied alone, with a clear in the same cycle, and held high after a clear, which separates edge capture from level capture and shows which of set and clear takes priority.

// File: rtl/clksel_pkg.sv
package clksel_pkg;

    // field widths
    localparam int XTAL_W = 5;
    localparam int OSC_W  = 2;
    localparam int LDIV_W = 4;
    localparam int XDIV_W = 6;
    localparam int MULT_W = 8;
    localparam int REFD_W = 4;
    localparam int DEFF_W = XDIV_W + 1;
    localparam int N_OSC  = 1 << OSC_W;

    // legacy word layout
    localparam int LG_BYP      = 0;
    localparam int LG_USEDIV   = 1;
    localparam int LG_PWRDN    = 2;
    localparam int LG_XTAL_LSB = 3;
    localparam int LG_OSC_LSB  = LG_XTAL_LSB + XTAL_W;
    localparam int LG_DIV_LSB  = LG_OSC_LSB + OSC_W;
    localparam int LG_W        = LG_DIV_LSB + LDIV_W;

    // extended word layout
    localparam int XR_EN      = 0;
    localparam int XR_BYP     = 1;
    localparam int XR_PWRDN   = 2;
    localparam int XR_OSC_LSB = 3;
    localparam int XR_DIV_LSB = XR_OSC_LSB + OSC_W;
    localparam int XR_W       = XR_DIV_LSB + XDIV_W;

    // register addresses
    localparam logic [1:0] ADDR_LG   = 2'd0;
    localparam logic [1:0] ADDR_XR   = 2'd1;
    localparam logic [1:0] ADDR_CLR  = 2'd2;
    localparam logic [1:0] ADDR_MASK = 2'd3;

    typedef enum logic [1:0] {
        PS_RAW    = 2'd0,
        PS_TO_PLL = 2'd1,
        PS_PLL    = 2'd2,
        PS_TO_RAW = 2'd3
    } path_state_e;

    typedef struct packed {
        logic              bypass;
        logic              use_div;
        logic              pwrdn;
        logic [XTAL_W-1:0] xtal;
        logic [OSC_W-1:0]  osc;
        logic [XDIV_W-1:0] sysdiv;
    } sel_cfg_t;

endpackage

// File: rtl/clksel_regs.sv
module clksel_regs
    import clksel_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int XTAL_MIN = 4,
    parameter int XTAL_MAX = 15,
    parameter int XTAL_RST = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              use_div_o,
    output logic [OSC_W-1:0]  osc_o,
    output logic [XDIV_W-1:0] sysdiv_o,
    output logic              mask_o,
    output logic              clr_o,
    output logic              xtal_bad_o,
    output logic              pwr_en_o,
    output logic              byp_eff_o,
    output logic [MULT_W-1:0] mult_o,
    output logic [REFD_W-1:0] refdiv_o
);

    localparam logic [LG_W-1:0] LG_RST =
        (LG_W'(1) << LG_BYP) | (LG_W'(1) << LG_PWRDN) |
        (LG_W'(XTAL_RST) << LG_XTAL_LSB);
    localparam logic [XTAL_W-1:0] XLO = XTAL_W'(XTAL_MIN);
    localparam logic [XTAL_W-1:0] XHI = XTAL_W'(XTAL_MAX);

    logic [LG_W-1:0] lg_q;
    logic [XR_W-1:0] xr_q;
    logic            mask_q;
    sel_cfg_t        cfg;
    logic            unused_data;

    assign unused_data = ^wr_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lg_q   <= LG_RST;
            xr_q   <= '0;
            mask_q <= 1'b0;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_LG:   lg_q   <= wr_data[LG_W-1:0];
                ADDR_XR:   xr_q   <= wr_data[XR_W-1:0];
                ADDR_MASK: mask_q <= wr_data[0];
                default:   ;
            endcase
        end
    end

    assign clr_o  = wr_en && (wr_addr == ADDR_CLR) && wr_data[0];
    assign mask_o = mask_q;

    // precedence: extended word overrides when enabled
    always_comb begin
        cfg.use_div = lg_q[LG_USEDIV];
        cfg.xtal    = lg_q[LG_XTAL_LSB +: XTAL_W];
        if (xr_q[XR_EN]) begin
            cfg.bypass = xr_q[XR_BYP];
            cfg.pwrdn  = xr_q[XR_PWRDN];
            cfg.osc    = xr_q[XR_OSC_LSB +: OSC_W];
            cfg.sysdiv = xr_q[XR_DIV_LSB +: XDIV_W];
        end else begin
            cfg.bypass = lg_q[LG_BYP];
            cfg.pwrdn  = lg_q[LG_PWRDN];
            cfg.osc    = lg_q[LG_OSC_LSB +: OSC_W];
            cfg.sysdiv = XDIV_W'(lg_q[LG_DIV_LSB +: LDIV_W]);
        end
    end

    // crystal table, computed
    always_comb begin
        xtal_bad_o = (cfg.xtal < XLO) || (cfg.xtal > XHI);
        if (xtal_bad_o) begin
            mult_o   = '0;
            refdiv_o = '0;
        end else begin
            mult_o   = MULT_W'({cfg.xtal, 1'b0}) + MULT_W'(8);
            refdiv_o = REFD_W'(cfg.xtal >> 2) + REFD_W'(1);
        end
    end

    assign pwr_en_o  = !cfg.pwrdn && !xtal_bad_o;
    assign byp_eff_o = cfg.bypass || !pwr_en_o;
    assign use_div_o = cfg.use_div;
    assign osc_o     = cfg.osc;
    assign sysdiv_o  = cfg.sysdiv;

endmodule

// File: rtl/clksel_fsm.sv
module clksel_fsm
    import clksel_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        byp_eff,
    output path_state_e state_o,
    output logic        raw_path_o,
    output logic        pll_path_o
);

    path_state_e state_q;
    path_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PS_RAW;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            PS_RAW:    state_d = byp_eff ? PS_RAW : PS_TO_PLL;
            PS_TO_PLL: state_d = byp_eff ? PS_RAW : PS_PLL;
            PS_PLL:    state_d = byp_eff ? PS_TO_RAW : PS_PLL;
            PS_TO_RAW: state_d = PS_RAW;
        endcase
    end

    always_comb begin
        raw_path_o = 1'b0;
        pll_path_o = 1'b0;
        unique case (state_q)
            PS_RAW:    raw_path_o = 1'b1;
            PS_PLL:    pll_path_o = 1'b1;
            PS_TO_PLL,
            PS_TO_RAW: ;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/clksel_div.sv
module clksel_div
    import clksel_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              src_tick,
    input  logic [DEFF_W-1:0] ratio,
    output logic              tick_o
);

    logic [DEFF_W-1:0] cnt_q;
    logic              wrap;

    assign wrap   = cnt_q >= (ratio - DEFF_W'(1));
    assign tick_o = active && src_tick && wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt_q <= '0;
        else if (!active)  cnt_q <= '0;
        else if (src_tick) cnt_q <= wrap ? '0 : cnt_q + DEFF_W'(1);
    end

endmodule

// File: rtl/clksel_lock.sv
module clksel_lock (
    input  logic clk,
    input  logic rst_n,
    input  logic lock_in,
    input  logic clr,
    input  logic mask,
    output logic raw_o,
    output logic irq_o
);

    logic lock_q;
    logic raw_q;
    logic rise;

    assign rise = lock_in && !lock_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_q <= 1'b0;
            raw_q  <= 1'b0;
        end else begin
            lock_q <= lock_in;
            if (rise)     raw_q <= 1'b1;
            else if (clr) raw_q <= 1'b0;
        end
    end

    assign raw_o = raw_q;
    assign irq_o = raw_q && mask;

endmodule

// File: rtl/pll_clk_selector.sv
module pll_clk_selector
    import clksel_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int XTAL_MIN = 4,
    parameter int XTAL_MAX = 15,
    parameter int XTAL_RST = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              pll_lock,
    input  logic [N_OSC-1:0]  osc_tick,
    input  logic              pll_tick,
    output logic              pll_pwr_en,
    output logic [MULT_W-1:0] pll_mult,
    output logic [REFD_W-1:0] pll_refdiv,
    output logic              xtal_bad,
    output logic [1:0]        src_state,
    output logic [DEFF_W-1:0] div_eff,
    output logic              sys_tick,
    output logic              lock_raw,
    output logic              lock_irq
);

    logic              use_div;
    logic [OSC_W-1:0]  osc_sel;
    logic [XDIV_W-1:0] sysdiv;
    logic              mask;
    logic              clr;
    logic              byp_eff;
    logic              raw_path;
    logic              pll_path;
    logic              div_tick;
    path_state_e       state;

    clksel_regs #(
        .DATA_W  (DATA_W),
        .XTAL_MIN(XTAL_MIN),
        .XTAL_MAX(XTAL_MAX),
        .XTAL_RST(XTAL_RST)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .use_div_o (use_div),
        .osc_o     (osc_sel),
        .sysdiv_o  (sysdiv),
        .mask_o    (mask),
        .clr_o     (clr),
        .xtal_bad_o(xtal_bad),
        .pwr_en_o  (pll_pwr_en),
        .byp_eff_o (byp_eff),
        .mult_o    (pll_mult),
        .refdiv_o  (pll_refdiv)
    );

    clksel_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .byp_eff   (byp_eff),
        .state_o   (state),
        .raw_path_o(raw_path),
        .pll_path_o(pll_path)
    );

    assign div_eff = (pll_path && use_div) ?
                     ({1'b0, sysdiv} + DEFF_W'(1)) : DEFF_W'(1);

    clksel_div u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (pll_path),
        .src_tick(pll_tick),
        .ratio   (div_eff),
        .tick_o  (div_tick)
    );

    clksel_lock u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .lock_in(pll_lock),
        .clr    (clr),
        .mask   (mask),
        .raw_o  (lock_raw),
        .irq_o  (lock_irq)
    );

    assign sys_tick  = raw_path ? osc_tick[osc_sel] : div_tick;
    assign src_state = state;

endmodule

// File: rtl/pll_clk_selector_chk.sv
module pll_clk_selector_chk
    import clksel_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              pll_lock,
    input logic              pll_tick,
    input logic              pll_pwr_en,
    input logic              xtal_bad,
    input logic [1:0]        src_state,
    input logic [DEFF_W-1:0] div_eff,
    input logic              sys_tick,
    input logic              lock_raw,
    input logic              lock_irq
);

    a_r9_gap_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (src_state == PS_TO_PLL || src_state == PS_TO_RAW) |-> !sys_tick);

    a_r9_leave_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (src_state == PS_TO_RAW) |=> (src_state == PS_RAW));

    a_r8_no_unpowered_pll: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_pwr_en |=> (src_state != PS_PLL));

    a_r3_bad_code_off: assert property (@(posedge clk) disable iff (!rst_n)
        xtal_bad |-> !pll_pwr_en);

    a_r6_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_lock) |=> lock_raw);

    a_r7_irq_needs_raw: assert property (@(posedge clk) disable iff (!rst_n)
        lock_irq |-> lock_raw);

    a_r2_tick_follows_source: assert property (@(posedge clk) disable iff (!rst_n)
        (src_state == PS_PLL && !pll_tick) |-> !sys_tick);

    a_r1_raw_ratio_one: assert property (@(posedge clk) disable iff (!rst_n)
        (src_state == PS_RAW) |-> (div_eff == DEFF_W'(1)));

endmodule

bind pll_clk_selector pll_clk_selector_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pll_lock  (pll_lock),
    .pll_tick  (pll_tick),
    .pll_pwr_en(pll_pwr_en),
    .xtal_bad  (xtal_bad),
    .src_state (src_state),
    .div_eff   (div_eff),
    .sys_tick  (sys_tick),
    .lock_raw  (lock_raw),
    .lock_irq  (lock_irq)
);

// File: tb/pll_clk_selector_tb_top.sv
`timescale 1ns/1ps
module pll_clk_selector_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [31:0] wr_data = 32'd0;
    logic        pll_lock = 1'b0;
    logic [3:0]  osc_tick = 4'd0;
    logic        pll_tick = 1'b1;
    logic        pll_pwr_en;
    logic [7:0]  pll_mult;
    logic [3:0]  pll_refdiv;
    logic        xtal_bad;
    logic [1:0]  src_state;
    logic [6:0]  div_eff;
    logic        sys_tick;
    logic        lock_raw;
    logic        lock_irq;

    int vec = 0;
    int bad = 0;
    bit done = 0;
    logic [31:0] cyc = 0;

    always #4 clk = ~clk;

    // co-prime periods 2,3,5,7 on the four oscillators
    always @(posedge clk) begin
        cyc      <= cyc + 1;
        osc_tick <= {(cyc % 7) == 0, (cyc % 5) == 0, (cyc % 3) == 0, (cyc % 2) == 0};
    end

    pll_clk_selector dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .pll_lock  (pll_lock),
        .osc_tick  (osc_tick),
        .pll_tick  (pll_tick),
        .pll_pwr_en(pll_pwr_en),
        .pll_mult  (pll_mult),
        .pll_refdiv(pll_refdiv),
        .xtal_bad  (xtal_bad),
        .src_state (src_state),
        .div_eff   (div_eff),
        .sys_tick  (sys_tick),
        .lock_raw  (lock_raw),
        .lock_irq  (lock_irq)
    );

    function automatic logic [31:0] lg(input bit byp, input bit ud, input bit pd,
                                       input int xt, input int os, input int dv);
        return 32'(byp) | (32'(ud) << 1) | (32'(pd) << 2) | (32'(xt & 31) << 3) |
               (32'(os & 3) << 8) | (32'(dv & 15) << 10);
    endfunction

    function automatic logic [31:0] xr(input bit en, input bit byp, input bit pd,
                                       input int os, input int dv);
        return 32'(en) | (32'(byp) << 1) | (32'(pd) << 2) | (32'(os & 3) << 3) |
               (32'(dv & 63) << 5);
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        vec++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // ends on the negedge just after the write edge
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic settle;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic raw_compare(input string req, input int s);
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            chk(req, "sys_tick vs osc", 32'(sys_tick), 32'(osc_tick[s]));
        end
    endtask

    // enter PLL from RAW and count pulses over a window
    task automatic pll_window(input string req, input logic [1:0] a, input logic [31:0] d,
                              input int ratio);
        int cnt;
        wr(a, d);
        @(negedge clk);
        chk("R9", "entering state", 32'(src_state), 32'd1);
        chk("R9", "gap tick", 32'(sys_tick), 32'd0);
        @(negedge clk);
        chk("R9", "pll state", 32'(src_state), 32'd2);
        chk(req, "div_eff", 32'(div_eff), 32'(ratio));
        cnt = 0;
        for (int j = 0; j < 130; j++) begin
            if (j > 0) @(negedge clk);
            cnt += int'(sys_tick);
        end
        chk(req, "pulse count", 32'(cnt), 32'(130 / ratio));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        chk("R10", "src_state", 32'(src_state), 32'd0);
        chk("R10", "pll_pwr_en", 32'(pll_pwr_en), 32'd0);
        chk("R10", "pll_mult", 32'(pll_mult), 32'd20);
        chk("R10", "pll_refdiv", 32'(pll_refdiv), 32'd2);
        chk("R10", "lock_raw", 32'(lock_raw), 32'd0);
        chk("R10", "lock_irq", 32'(lock_irq), 32'd0);
        chk("R10", "div_eff", 32'(div_eff), 32'd1);

        // R4 / R3 / R8 crystal sweep
        for (int c = 0; c < 32; c++) begin
            bit ok;
            ok = (c >= 4) && (c <= 15);
            wr(2'd0, lg(0, 0, 0, c, 0, 0));
            settle();
            chk("R4", "xtal_bad", 32'(xtal_bad), 32'(!ok));
            chk("R4", "pll_mult", 32'(pll_mult), ok ? 32'(2 * c + 8) : 32'd0);
            chk("R4", "pll_refdiv", 32'(pll_refdiv), ok ? 32'(c / 4 + 1) : 32'd0);
            chk("R3", "pll_pwr_en", 32'(pll_pwr_en), 32'(ok));
            chk("R8", "src_state", 32'(src_state), ok ? 32'd2 : 32'd0);
        end

        // R1 raw path, legacy select and extended override (R5)
        for (int s = 0; s < 4; s++) begin
            wr(2'd1, xr(0, 0, 0, 0, 0));
            wr(2'd0, lg(1, 1, 0, 6, s, 9));
            settle(); @(negedge clk);
            chk("R1", "src_state", 32'(src_state), 32'd0);
            chk("R1", "div_eff", 32'(div_eff), 32'd1);
            raw_compare("R1", s);
            wr(2'd0, lg(0, 1, 0, 6, 3 - s, 9));
            wr(2'd1, xr(1, 1, 0, s, 20));
            settle(); @(negedge clk);
            chk("R5", "src_state ext bypass", 32'(src_state), 32'd0);
            raw_compare("R5", s);
        end

        // R8 power-down forces raw even with bypass clear
        wr(2'd1, xr(0, 0, 0, 0, 0));
        wr(2'd0, lg(0, 1, 1, 6, 2, 3));
        settle(); @(negedge clk);
        chk("R8", "pwrdn src_state", 32'(src_state), 32'd0);
        chk("R3", "pwrdn pll_pwr_en", 32'(pll_pwr_en), 32'd0);
        raw_compare("R8", 2);

        // R2 legacy divider sweep
        for (int d = 0; d < 16; d++) begin
            wr(2'd0, lg(1, 1, 0, 6, 0, d));
            settle(); @(negedge clk);
            pll_window("R2", 2'd0, lg(0, 1, 0, 6, 0, d), d + 1);
        end
        // R2 use-divider clear: undivided
        wr(2'd0, lg(1, 0, 0, 6, 0, 5));
        settle(); @(negedge clk);
        pll_window("R2", 2'd0, lg(0, 0, 0, 6, 0, 5), 1);

        // R5 extended divider sweep over legacy bypass
        wr(2'd0, lg(1, 1, 0, 6, 0, 15));
        for (int d = 0; d < 64; d++) begin
            wr(2'd1, xr(0, 0, 0, 0, 0));
            settle(); @(negedge clk);
            pll_window("R5", 2'd1, xr(1, 0, 0, 0, d), d + 1);
        end

        // R5 extended power-down overrides legacy
        wr(2'd0, lg(0, 1, 0, 6, 0, 2));
        wr(2'd1, xr(1, 0, 1, 0, 2));
        settle();
        chk("R5", "ext pwrdn pll_pwr_en", 32'(pll_pwr_en), 32'd0);
        chk("R5", "ext pwrdn src_state", 32'(src_state), 32'd0);
        // R5 extended word ignored while disabled
        wr(2'd1, xr(0, 1, 1, 1, 40));
        settle();
        chk("R5", "disabled ext pwr", 32'(pll_pwr_en), 32'd1);
        chk("R5", "disabled ext src_state", 32'(src_state), 32'd2);
        chk("R5", "disabled ext div_eff", 32'(div_eff), 32'd3);

        // R6 / R7 lock status
        @(negedge clk); pll_lock = 1'b1;
        @(negedge clk);
        chk("R6", "set on rise", 32'(lock_raw), 32'd1);
        chk("R7", "masked irq", 32'(lock_irq), 32'd0);
        wr(2'd3, 32'd1);
        chk("R7", "unmasked irq", 32'(lock_irq), 32'd1);
        wr(2'd2, 32'd1);
        chk("R6", "cleared", 32'(lock_raw), 32'd0);
        chk("R7", "irq after clear", 32'(lock_irq), 32'd0);
        repeat (3) @(negedge clk);
        chk("R6", "level does not reset", 32'(lock_raw), 32'd0);
        pll_lock = 1'b0;
        @(negedge clk); pll_lock = 1'b1;
        @(negedge clk);
        chk("R6", "second rise", 32'(lock_raw), 32'd1);
        wr(2'd2, 32'd0);
        chk("R6", "zero write keeps", 32'(lock_raw), 32'd1);
        wr(2'd2, 32'd1);
        pll_lock = 1'b0;
        @(negedge clk);
        pll_lock = 1'b1;
        wr_en = 1'b1; wr_addr = 2'd2; wr_data = 32'd1;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R6", "set beats clear", 32'(lock_raw), 32'd1);
        wr(2'd3, 32'd0);
        chk("R7", "mask off", 32'(lock_irq), 32'd0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    initial begin
        #1500000;
        if (!done) begin
            bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    end

endmodule